// File: doc/BRIEF.md
# CAM Command Decoder and Address Sequencer

This block sits in front of a small content-addressable memory and its register file. It accepts 16-bit command words, one per asserted `cmd_wr` cycle, and splits them into four families: data move, validity-bit control, compare and special operations. For each accepted command it raises a one-cycle strobe and presents the decoded fields. The memory array and register file downstream act on that strobe and those fields. The memory array, the data shifters and the segment counters are outside this block.

The block keeps an address register for memory-addressed operations. Move and validity commands carry a flag in bit 11. When the flag is set, the next command write is taken as an absolute address, and the operation runs only after that address has arrived. After every operation that touches memory, the address register steps by one. A direction bit, loaded through `ctl_wr`, chooses whether the step goes up or down. Two copies of the address register and the direction bit exist: a foreground copy and a background copy. Two special operations choose which copy is active.

Top module: `cam_cmd_seq`

## Requirements
- R1: After reset the following are all 0: every strobe, `busy`, `err`, `bank`, `ar_out`, `op_addr` and every field output. Both direction bits are 0, which means up.
- R2: A legal command that is not deferred drives its results one clock after the write edge. In that cycle exactly one of the strobes `mov_stb`, `vbc_stb`, `cmp_stb`, `spc_stb` or `err` is high, and only for one cycle. With `cmd_wr` low, nothing changes except through `ctl_wr`.
- R3: The move pattern is `0000 f011 mm ddd sss`. It gives `mask_sel`=mm and `dst`=ddd. Destination code 3'b100 means memory. In that case `vld_set`=bit 2 and `src`={0,bits 1:0}. Otherwise `src`=sss and `vld_set`=0.
- R4: A move whose destination and source are the same non-memory code updates the fields but raises no strobe and no error.
- R5: The validity pattern is `0000 f100 00 ddd vvv`. It gives `vbc_stb`, `dst`=ddd and `cond`=vvv. Target code 3'b100 means memory.
- R6: The compare pattern is `0000 0101 00000 vvv`. It gives `cmp_stb` and `cond`=vvv.
- R7: The special pattern is `0000 0110 00 ddd rrr`, with rrr from 0 to 4. It gives `spc_stb`, `dst`=ddd and `cond`=rrr. For rrr=0 the foreground copy becomes active and `bank`=0. For rrr=1 the background copy becomes active and `bank`=1. For rrr=2, `rsc_stb` also pulses to reset both segment counters.
- R8: A move or validity command with bit 11 set raises `busy` from the next cycle. `busy` stays high until the next write. That write's low AW bits are loaded into the active address register, and the deferred operation's results appear one cycle after that second write. The second write is never decoded as a command.
- R9: A move that names memory as destination or source, and a validity command whose target is memory, are memory operations. For these, `mem_op` pulses and `op_addr` shows the address used. Afterwards the active address register holds that address plus 1 (direction 0) or minus 1 (direction 1), wrapping modulo 2^AW. For any other command, `op_addr` shows the active address and the register does not step.
- R10: `ctl_wr` writes `ctl_dir` into the direction bit of the active copy only. A step in the same cycle uses the previous value.
- R11: Each copy keeps its own address and direction. `ar_out` shows the active copy's address register.
- R12: A write is unrecognised in any of these cases: the top nibble is non-zero, bits 10:8 are outside 011 to 110, a bit that must be zero is set, or a special op code is above 4. An unrecognised write raises `err` for one cycle and changes no other output or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command word valid this cycle |
| cmd | input | 16 | Command word or absolute address |
| ctl_wr | input | 1 | Write the active copy's step direction |
| ctl_dir | input | 1 | Step direction, 0 up, 1 down |
| busy | output | 1 | Waiting for the absolute address write |
| err | output | 1 | Unrecognised command pulse |
| mov_stb | output | 1 | Data move strobe |
| vbc_stb | output | 1 | Validity control strobe |
| cmp_stb | output | 1 | Compare strobe |
| spc_stb | output | 1 | Special operation strobe |
| rsc_stb | output | 1 | Segment counter reset strobe |
| mem_op | output | 1 | The operation addresses memory |
| mask_sel | output | 2 | Move mask select |
| dst | output | 3 | Destination or target code |
| src | output | 3 | Move source code |
| vld_set | output | 1 | Mark memory entry valid on move |
| cond | output | 3 | Validity state, compare condition or special op |
| op_addr | output | AW | Address used by the operation |
| bank | output | 1 | Active copy, 0 foreground, 1 background |
| ar_out | output | AW | Active address register |

## Verification
Every strobe and field output is registered. A direct command's results are due in the cycle after its write edge. A deferred command's results are due in the cycle after the address write, and `busy` covers the cycle or cycles between the two writes. The address register's stepped value and a new `bank` value become visible together with the strobe that caused them. The bench's reference model updates at the same rising edge as the design and compares every output at the following falling edge, so each result is checked in the exact cycle it is due. The stimulus includes back-to-back writes, writes at the wrap points 0 and 2^AW-1, and direction changes while each copy is active.

// File: rtl/cam_cmd_seq.sv
module cam_cmd_seq #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [15:0]   cmd,
  input  logic          ctl_wr,
  input  logic          ctl_dir,
  output logic          busy,
  output logic          err,
  output logic          mov_stb,
  output logic          vbc_stb,
  output logic          cmp_stb,
  output logic          spc_stb,
  output logic          rsc_stb,
  output logic          mem_op,
  output logic [1:0]    mask_sel,
  output logic [2:0]    dst,
  output logic [2:0]    src,
  output logic          vld_set,
  output logic [2:0]    cond,
  output logic [AW-1:0] op_addr,
  output logic          bank,
  output logic [AW-1:0] ar_out
);

  localparam logic [2:0] MEM     = 3'b100;
  localparam logic [2:0] G_MOV   = 3'b011;
  localparam logic [2:0] G_VBC   = 3'b100;
  localparam logic [2:0] G_CMP   = 3'b101;
  localparam logic [2:0] G_SPC   = 3'b110;
  localparam logic [2:0] OP_FG   = 3'd0;
  localparam logic [2:0] OP_BG   = 3'd1;
  localparam logic [2:0] OP_RSC  = 3'd2;
  localparam logic [2:0] OP_LAST = 3'd4;

  logic [AW-1:0] ar_q [2];
  logic          dir_q [2];
  logic          wait_q;
  logic [15:0]   held_q;

  logic [15:0]   cur;
  logic [2:0]    grp, fd, fs;
  logic          top_ok, is_mov, is_vbc, is_cmp, is_spc, legal;
  logic          mem_dst, mem_src, same_reg, touch_mem;
  logic          accept_new, take_abs, exec;
  logic [AW-1:0] base, stepped;

  assign cur    = wait_q ? held_q : cmd;
  assign grp    = cur[10:8];
  assign top_ok = (cur[15:12] == 4'b0000);

  assign is_mov = top_ok && (grp == G_MOV);
  assign is_vbc = top_ok && (grp == G_VBC) && (cur[7:6] == 2'b00);
  assign is_cmp = top_ok && (grp == G_CMP) && !cur[11] && (cur[7:3] == 5'b0);
  assign is_spc = top_ok && (grp == G_SPC) && !cur[11] && (cur[7:6] == 2'b00)
                  && (cur[2:0] <= OP_LAST);
  assign legal  = is_mov || is_vbc || is_cmp || is_spc;

  assign fd       = cur[5:3];
  assign mem_dst  = (fd == MEM);
  assign fs       = mem_dst ? {1'b0, cur[1:0]} : cur[2:0];
  assign mem_src  = !mem_dst && (fs == MEM);
  assign same_reg = !mem_dst && (fd == fs);
  assign touch_mem = (is_mov && (mem_dst || mem_src)) || (is_vbc && mem_dst);

  assign accept_new = cmd_wr && !wait_q;
  assign take_abs   = accept_new && (is_mov || is_vbc) && cur[11];
  assign exec       = (accept_new && legal && !take_abs) || (wait_q && cmd_wr);

  assign base    = wait_q ? cmd[AW-1:0] : ar_q[bank];
  assign stepped = dir_q[bank] ? base - 1'b1 : base + 1'b1;

  assign busy   = wait_q;
  assign ar_out = ar_q[bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q[0]  <= '0;
      ar_q[1]  <= '0;
      dir_q[0] <= 1'b0;
      dir_q[1] <= 1'b0;
      wait_q   <= 1'b0;
      held_q   <= '0;
      bank     <= 1'b0;
      err      <= 1'b0;
      mov_stb  <= 1'b0;
      vbc_stb  <= 1'b0;
      cmp_stb  <= 1'b0;
      spc_stb  <= 1'b0;
      rsc_stb  <= 1'b0;
      mem_op   <= 1'b0;
      mask_sel <= '0;
      dst      <= '0;
      src      <= '0;
      vld_set  <= 1'b0;
      cond     <= '0;
      op_addr  <= '0;
    end else begin
      err     <= 1'b0;
      mov_stb <= 1'b0;
      vbc_stb <= 1'b0;
      cmp_stb <= 1'b0;
      spc_stb <= 1'b0;
      rsc_stb <= 1'b0;
      mem_op  <= 1'b0;

      if (ctl_wr) dir_q[bank] <= ctl_dir;

      if (accept_new && !legal) err <= 1'b1;

      if (take_abs) begin
        wait_q <= 1'b1;
        held_q <= cmd;
      end

      if (exec) begin
        wait_q  <= 1'b0;
        mov_stb <= is_mov && !same_reg;
        vbc_stb <= is_vbc;
        cmp_stb <= is_cmp;
        spc_stb <= is_spc;
        rsc_stb <= is_spc && (cur[2:0] == OP_RSC);
        mem_op  <= touch_mem;
        op_addr <= base;
        mask_sel <= is_mov ? cur[7:6] : 2'b00;
        dst      <= is_cmp ? 3'b000 : fd;
        src      <= is_mov ? fs : 3'b000;
        vld_set  <= is_mov && mem_dst && cur[2];
        cond     <= is_mov ? 3'b000 : cur[2:0];
        if (touch_mem)   ar_q[bank] <= stepped;
        else if (wait_q) ar_q[bank] <= base;
        if (is_spc && cur[2:0] == OP_FG) bank <= 1'b0;
        if (is_spc && cur[2:0] == OP_BG) bank <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_cmd_seq_chk.sv
module cam_cmd_seq_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [15:0]   cmd,
  input logic          busy,
  input logic          err,
  input logic          mov_stb,
  input logic          vbc_stb,
  input logic          cmp_stb,
  input logic          spc_stb,
  input logic          rsc_stb,
  input logic          mem_op,
  input logic [AW-1:0] op_addr,
  input logic [AW-1:0] ar_out
);

  logic [AW-1:0] up1, dn1;
  assign up1 = op_addr + 1'b1;
  assign dn1 = op_addr - 1'b1;

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mov_stb, vbc_stb, cmp_stb, spc_stb, err}));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !(mov_stb || vbc_stb || cmp_stb || spc_stb || err));

  p_defer_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && cmd[15:12] == 4'b0 && cmd[11] &&
     (cmd[10:8] == 3'b011 || (cmd[10:8] == 3'b100 && cmd[7:6] == 2'b00))) |=> busy);

  p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> !busy);

  p_busy_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(err || mov_stb || vbc_stb || cmp_stb || spc_stb));

  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_op |-> (ar_out == up1 || ar_out == dn1));

  p_rsc_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsc_stb |-> spc_stb);

endmodule

bind cam_cmd_seq cam_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .busy(busy),
  .err(err), .mov_stb(mov_stb), .vbc_stb(vbc_stb), .cmp_stb(cmp_stb),
  .spc_stb(spc_stb), .rsc_stb(rsc_stb), .mem_op(mem_op),
  .op_addr(op_addr), .ar_out(ar_out)
);

// File: tb/test_cam_cmd_seq.sv
module test_cam_cmd_seq;
  localparam int AW = 10;
  localparam int PERIOD = 10;
  localparam int MODV = 1 << AW;

  logic clk = 0, rst_n = 0, cmd_wr = 0, ctl_wr = 0, ctl_dir = 0;
  logic [15:0] cmd = 0;
  logic busy, err, mov_stb, vbc_stb, cmp_stb, spc_stb, rsc_stb, mem_op, vld_set, bank;
  logic [1:0] mask_sel;
  logic [2:0] dst, src, cond;
  logic [AW-1:0] op_addr, ar_out;

  cam_cmd_seq #(.AW(AW)) i_cam_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(cmd), .ctl_wr(ctl_wr),
    .ctl_dir(ctl_dir), .busy(busy), .err(err), .mov_stb(mov_stb),
    .vbc_stb(vbc_stb), .cmp_stb(cmp_stb), .spc_stb(spc_stb), .rsc_stb(rsc_stb),
    .mem_op(mem_op), .mask_sel(mask_sel), .dst(dst), .src(src),
    .vld_set(vld_set), .cond(cond), .op_addr(op_addr), .bank(bank), .ar_out(ar_out)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  int m_ar[2], m_dir[2], m_bank, m_wait, m_held;
  int e_err, e_mov, e_vbc, e_cmp, e_spc, e_rsc, e_mem;
  int e_mask, e_dst, e_src, e_vld, e_cond, e_opaddr;
  int k, base, old_dir, ex, absld, c, ismem;

  function automatic int kind(input logic [15:0] w);
    casez (w)
      16'b0000_?011_????_????: return 1;
      16'b0000_?100_00??_????: return 2;
      16'b0000_0101_0000_0???: return 3;
      16'b0000_0110_00??_????: return (w[2:0] < 5) ? 4 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_ar[0] = 0; m_ar[1] = 0; m_dir[0] = 0; m_dir[1] = 0;
    m_bank = 0; m_wait = 0; m_held = 0;
    e_err = 0; e_mov = 0; e_vbc = 0; e_cmp = 0; e_spc = 0; e_rsc = 0; e_mem = 0;
    e_mask = 0; e_dst = 0; e_src = 0; e_vld = 0; e_cond = 0; e_opaddr = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      e_err = 0; e_mov = 0; e_vbc = 0; e_cmp = 0; e_spc = 0; e_rsc = 0; e_mem = 0;
      old_dir = m_dir[m_bank];
      if (ctl_wr) m_dir[m_bank] = ctl_dir;   // R10
      ex = 0; absld = 0; c = 0; base = 0;
      if (cmd_wr) begin
        if (m_wait != 0) begin
          c = m_held; ex = 1; absld = 1; base = cmd % MODV; m_wait = 0;
        end else begin
          c = cmd; base = m_ar[m_bank];
          k = kind(cmd);
          if (k == 0) e_err = 1;
          else if ((k == 1 || k == 2) && cmd[11]) begin m_wait = 1; m_held = cmd; end
          else ex = 1;
        end
      end
      if (ex != 0) begin
        k = kind(c[15:0]);
        ismem = 0;
        e_mask = 0; e_src = 0; e_vld = 0; e_cond = 0; e_dst = (c >> 3) & 7;
        if (k == 1) begin
          e_mask = (c >> 6) & 3;
          if (e_dst == 4) begin e_src = c & 3; e_vld = (c >> 2) & 1; ismem = 1; end
          else begin e_src = c & 7; if (e_src == 4) ismem = 1; end
          e_mov = (e_dst != 4 && e_dst == e_src) ? 0 : 1;
        end else if (k == 2) begin
          e_vbc = 1; e_cond = c & 7; if (e_dst == 4) ismem = 1;
        end else if (k == 3) begin
          e_cmp = 1; e_cond = c & 7; e_dst = 0;
        end else begin
          e_spc = 1; e_cond = c & 7;
          if (e_cond == 2) e_rsc = 1;
        end
        e_mem = ismem;
        e_opaddr = base;
        if (ismem != 0) m_ar[m_bank] = (base + (old_dir != 0 ? MODV - 1 : 1)) % MODV;
        else if (absld != 0) m_ar[m_bank] = base;
        if (k == 4 && e_cond == 0) m_bank = 0;
        if (k == 4 && e_cond == 1) m_bank = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R8 busy", busy, m_wait);
      chk("R12 err", err, e_err);
      chk("R3/R4 mov_stb", mov_stb, e_mov);
      chk("R5 vbc_stb", vbc_stb, e_vbc);
      chk("R6 cmp_stb", cmp_stb, e_cmp);
      chk("R7 spc_stb", spc_stb, e_spc);
      chk("R7 rsc_stb", rsc_stb, e_rsc);
      chk("R9 mem_op", mem_op, e_mem);
      chk("R3 mask_sel", mask_sel, e_mask);
      chk("R3 dst", dst, e_dst);
      chk("R3 src", src, e_src);
      chk("R3 vld_set", vld_set, e_vld);
      chk("R5 cond", cond, e_cond);
      chk("R9 op_addr", op_addr, e_opaddr);
      chk("R11 bank", bank, m_bank);
      chk("R11 ar_out", ar_out, m_ar[m_bank]);
    end
  end

  task automatic put(input logic [15:0] w);
    @(negedge clk); cmd_wr = 1; cmd = w;
    @(negedge clk); cmd_wr = 0; cmd = 16'h0;
  endtask

  task automatic burst(input logic [15:0] w);
    @(negedge clk); cmd_wr = 1; cmd = w;
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk); ctl_wr = 1; ctl_dir = d;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state is compared on these edges
    rst_n = 1;
    repeat (2) @(negedge clk);
    put(16'h0312);            // R3 register move, mask 00 dst 2 src 2? -> same-reg R4
    put(16'h03D9);            // R3 mask 11 dst 3 src 1
    put(16'h0326);            // R3 dst 4 memory, vld 1, src 2 -> R9 step up
    put(16'h0304);            // R9 memory source
    set_dir(1);               // R10 down
    put(16'h0425);            // R5 VBC memory target, R9 step down
    put(16'h0407);            // R5 non-memory target
    put(16'h0503);            // R6 compare
    put(16'h0B20);            // R8 deferred move to memory
    put(16'h0000);            // address 0, step down wraps
    put(16'h0C25);            // R8 deferred VBC
    put(16'hFFFF);            // address 1023 (low bits)
    put(16'h0612);            // R7 rsc
    put(16'h0603);            // R7 shift
    put(16'h0604);            // R7 shift other
    put(16'h0601);            // R7 background
    put(16'h0324);            // R11 memory move on bg copy
    set_dir(1);               // R10 bg direction
    put(16'h0324);
    put(16'h0600);            // R7 back to foreground
    put(16'h0324);            // R11 fg copy kept its own state
    put(16'h1324);            // R12 bad top nibble
    put(16'h0724);            // R12 bad group
    put(16'h0465);            // R12 VBC nonzero fixed bits
    put(16'h0D01);            // R12 compare with flag
    put(16'h0508);            // R12 compare nonzero bits
    put(16'h0605);            // R12 special op 5
    put(16'h0E01);            // R12 special with flag
    put(16'h0000);            // R12 group 000
    burst(16'h0324); burst(16'h0503); burst(16'h0B03); burst(16'h03FF);
    burst(16'h0601); burst(16'h0F00); burst(16'h0324);
    @(negedge clk); cmd_wr = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (($urandom % 4) != 0) w[15:12] = 4'b0;
      if (($urandom % 3) != 0) w[7:6] = 2'b0;
      if (($urandom % 5) == 0) begin
        @(negedge clk); ctl_wr = 1; ctl_dir = 1'($urandom);
        @(negedge clk); ctl_wr = 0;
      end
      if (($urandom % 2) != 0) put(w); else burst(w);
    end
    @(negedge clk); cmd_wr = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule